// File: doc/BRIEF.md
# Sequential Double-Width Integer Divider

This unit divides a dividend twice as wide as the operand by a single-width divisor. It works on 8, 16, 32 or 64-bit operands, chosen for each operation, and in signed or unsigned mode. It retires one restoring quotient bit per clock. A caller raises `start` for one cycle while `busy` is low. The unit then holds `busy` until it raises `done` for one cycle. At that point it presents either a fresh quotient and remainder or the `div_err` flag.

The error rules match those of a processor divide instruction. A zero divisor fails. So does any quotient that cannot be represented in the operand width. When the upper dividend half already reaches the divisor, the operation fails at once, without iterating. Signed operation divides magnitudes and then fixes the signs. Negative quotients may reach one step further than positive ones. The remainder follows the sign of the dividend. Condition flags are not produced.

Top module: `seq_div_top`

## Requirements
- R1: After reset, `busy`, `done` and `div_err` are low, and `quot` and `rem` are zero.
- R2: The `width_sel` input selects the operand width n. Code 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. The divisor is `divisor[n-1:0]`. For n of 16 or more, the dividend is {`dvd_hi[n-1:0]`, `dvd_lo[n-1:0]`}. For n = 8, the dividend is `dvd_lo[15:0]`. Operand bits outside these fields are ignored.
- R3: In unsigned mode (`op_signed` = 0), a successful operation returns the truncated quotient and the remainder of the 2n-bit dividend divided by the n-bit divisor.
- R4: A zero divisor raises `div_err` together with `done`, two clock edges after the accepting edge. `quot` and `rem` keep the values they held before.
- R5: When the upper dividend half (or its magnitude, in signed mode) is greater than or equal to the divisor (or its magnitude), the operation ends with `div_err`. `done` rises two clock edges after the accepting edge, with no iteration. `quot` and `rem` are unchanged.
- R6: In signed mode, the quotient is negative exactly when the operand signs differ, and it is truncated toward zero. A nonzero remainder has the sign of the dividend. Both are returned in two's complement, n bits wide.
- R7: In signed mode, a quotient of -2^(n-1) is accepted. A quotient of +2^(n-1) or more, or below -2^(n-1), raises `div_err` and leaves `quot` and `rem` unchanged.
- R8: For n = 8, `quot[7:0]` carries the quotient and `quot[15:8]` the remainder. All other `quot` bits and all of `rem` are zero.
- R9: For n of 16, 32 or 64, `quot` carries the quotient and `rem` the remainder, each zero above bit n-1.
- R10: An operation that passes the early checks raises `done` n+2 clock edges after the accepting edge. `busy` is high from the accepting edge until `done` rises.
- R11: `done` is high for exactly one cycle per operation, and never while `busy` is high.
- R12: A `start` pulse while `busy` is high is ignored: the running operation completes with its own result and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted while `busy` is low) |
| op_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| width_sel | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| dvd_hi | input | 64 | Upper dividend half |
| dvd_lo | input | 64 | Lower dividend half (whole dividend for 8-bit) |
| divisor | input | 64 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| div_err | output | 1 | Divide error, valid with `done` |
| quot | output | 64 | Quotient (for 8-bit: remainder and quotient packed) |
| rem | output | 64 | Remainder (zero for 8-bit) |

## Verification
Hand-picked unsigned cases at every width separate a correct bit loop from one that drops the bit shifted out of the partial remainder, or that takes the dividend from the wrong field. Signed cases include mixed signs, a negative dividend with an odd result, and quotients at exactly -2^(n-1) and +2^(n-1). These separate the asymmetric limit check and the sign of the remainder from a symmetric or sign-blind version. Zero divisors and upper halves equal to the divisor confirm the short error path and the held results. A mid-run start, followed by a long run of mixed random operations, covers the ignored request and the cycle-exact `busy`/`done` timing.

// File: rtl/seq_div_pkg.sv
package seq_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } div_state_e;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2,
    WID_64 = 2'd3
  } div_width_e;
endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
  parameter int W = 64
) (
  input  logic         sgn,
  input  logic [1:0]   wsel,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] mag_hi,
  output logic [W-1:0] mag_lo,
  output logic [W-1:0] mag_d,
  output logic         neg_q,
  output logic         neg_r,
  output logic         zero_div,
  output logic         early_ovf
);
  import seq_div_pkg::*;

  logic [W-1:0] mask, topb, hi, lo, d, lo_n, hi_n, d_n;
  logic         sa, sb;

  always_comb begin
    mask = {W{1'b1}} >> (W - (8 << wsel));
    topb = mask ^ (mask >> 1);
    if (wsel == WID_8) begin
      hi = W'(dvd_lo[15:8]);
      lo = W'(dvd_lo[7:0]);
    end else begin
      hi = dvd_hi & mask;
      lo = dvd_lo & mask;
    end
    d    = divisor & mask;
    sa   = sgn & (|(hi & topb));
    sb   = sgn & (|(d & topb));
    lo_n = (~lo + W'(1)) & mask;
    hi_n = (~hi + W'(lo == '0)) & mask;
    d_n  = (~d + W'(1)) & mask;
    mag_lo    = sa ? lo_n : lo;
    mag_hi    = sa ? hi_n : hi;
    mag_d     = sb ? d_n  : d;
    neg_q     = sa ^ sb;
    neg_r     = sa;
    zero_div  = (d == '0);
    early_ovf = zero_div | (mag_hi >= mag_d);
  end
endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
  parameter int W = 64
) (
  input  logic [1:0]   wsel,
  input  logic [W-1:0] r_cur,
  input  logic [W-1:0] a_cur,
  input  logic [W-1:0] d_cur,
  output logic [W-1:0] r_nx,
  output logic [W-1:0] a_nx
);
  logic [W-1:0] mask, topb, r_sh;
  logic         out_bit, in_bit, take;

  always_comb begin
    mask    = {W{1'b1}} >> (W - (8 << wsel));
    topb    = mask ^ (mask >> 1);
    out_bit = |(r_cur & topb);
    in_bit  = |(a_cur & topb);
    r_sh    = ((r_cur << 1) | W'(in_bit)) & mask;
    take    = out_bit | (r_sh >= d_cur);
    r_nx    = take ? ((r_sh - d_cur) & mask) : r_sh;
    a_nx    = ((a_cur << 1) | W'(take)) & mask;
  end
endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
  parameter int W = 64
) (
  input  logic         sgn,
  input  logic [1:0]   wsel,
  input  logic         neg_q,
  input  logic         neg_r,
  input  logic [W-1:0] q_mag,
  input  logic [W-1:0] r_mag,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         ovf
);
  import seq_div_pkg::*;

  logic [W-1:0] mask, topb, qs, rs;

  always_comb begin
    mask = {W{1'b1}} >> (W - (8 << wsel));
    topb = mask ^ (mask >> 1);
    qs   = (sgn && neg_q) ? ((~q_mag + W'(1)) & mask) : q_mag;
    rs   = (sgn && neg_r) ? ((~r_mag + W'(1)) & mask) : r_mag;
    if (!sgn)
      ovf = 1'b0;
    else if (neg_q)
      ovf = (q_mag > topb);
    else
      ovf = |(q_mag & topb);
    if (wsel == WID_8) begin
      quot = W'({rs[7:0], qs[7:0]});
      rem  = '0;
    end else begin
      quot = qs;
      rem  = rs;
    end
  end
endmodule

// File: rtl/seq_div_top.sv
module seq_div_top #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_signed,
  input  logic [1:0]   width_sel,
  input  logic [W-1:0] dvd_hi,
  input  logic [W-1:0] dvd_lo,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic         div_err,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem
);
  import seq_div_pkg::*;

  localparam int CW = $clog2(W) + 1;

  div_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0] r_q, r_d, a_q, a_d, d_q, d_d;
  logic [1:0]   ws_q, ws_d;
  logic         sg_q, sg_d, nq_q, nq_d, nr_q, nr_d, ep_q, ep_d;
  logic         done_q, done_d, err_q, err_d;
  logic [W-1:0] quot_q, quot_d, rem_q, rem_d;

  logic [W-1:0] p_hi, p_lo, p_d;
  logic         p_nq, p_nr, p_zero, p_early;
  logic [W-1:0] s_r, s_a;
  logic [W-1:0] f_quot, f_rem;
  logic         f_ovf;
  logic         accept, res_en;

  div_operand_prep #(.W(W)) u_prep (
    .sgn(op_signed), .wsel(width_sel), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo),
    .divisor(divisor), .mag_hi(p_hi), .mag_lo(p_lo), .mag_d(p_d),
    .neg_q(p_nq), .neg_r(p_nr), .zero_div(p_zero), .early_ovf(p_early)
  );

  div_restore_step #(.W(W)) u_step (
    .wsel(ws_q), .r_cur(r_q), .a_cur(a_q), .d_cur(d_q),
    .r_nx(s_r), .a_nx(s_a)
  );

  div_result_fix #(.W(W)) u_fix (
    .sgn(sg_q), .wsel(ws_q), .neg_q(nq_q), .neg_r(nr_q),
    .q_mag(a_q), .r_mag(r_q), .quot(f_quot), .rem(f_rem), .ovf(f_ovf)
  );

  assign accept = (st_q == ST_IDLE) && start;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    r_d    = r_q;
    a_d    = a_q;
    d_d    = d_q;
    ws_d   = ws_q;
    sg_d   = sg_q;
    nq_d   = nq_q;
    nr_d   = nr_q;
    ep_d   = ep_q;
    done_d = 1'b0;
    err_d  = err_q;
    res_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          ws_d = width_sel;
          sg_d = op_signed;
          nq_d = p_nq;
          nr_d = p_nr;
          r_d  = p_hi;
          a_d  = p_lo;
          d_d  = p_d;
          ep_d = p_early;
          cnt_d = CW'((8 << width_sel) - 1);
          st_d = p_early ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        r_d = s_r;
        a_d = s_a;
        if (cnt_q == '0) st_d = ST_FIN;
        else             cnt_d = cnt_q - CW'(1);
      end
      ST_FIN: begin
        done_d = 1'b1;
        err_d  = ep_q | f_ovf;
        res_en = !(ep_q | f_ovf);
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    quot_d = res_en ? f_quot : quot_q;
    rem_d  = res_en ? f_rem  : rem_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      r_q    <= '0;
      a_q    <= '0;
      d_q    <= '0;
      ws_q   <= '0;
      sg_q   <= 1'b0;
      nq_q   <= 1'b0;
      nr_q   <= 1'b0;
      ep_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      quot_q <= '0;
      rem_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      r_q    <= r_d;
      a_q    <= a_d;
      d_q    <= d_d;
      ws_q   <= ws_d;
      sg_q   <= sg_d;
      nq_q   <= nq_d;
      nr_q   <= nr_d;
      ep_q   <= ep_d;
      done_q <= done_d;
      err_q  <= err_d;
      quot_q <= quot_d;
      rem_q  <= rem_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign done    = done_q;
  assign div_err = err_q;
  assign quot    = quot_q;
  assign rem     = rem_q;
endmodule

// File: rtl/seq_div_chk.sv
module seq_div_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [1:0]   width_sel,
  input logic [W-1:0] divisor,
  input logic         busy,
  input logic         done,
  input logic         div_err,
  input logic [W-1:0] quot,
  input logic [W-1:0] rem
);
  logic       zdiv;
  logic [7:0] busy_run;

  always_comb begin
    case (width_sel)
      2'd0:    zdiv = (divisor[7:0] == '0);
      2'd1:    zdiv = (divisor[15:0] == '0);
      2'd2:    zdiv = (divisor[31:0] == '0);
      default: zdiv = (divisor == '0);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 8'd1;
    else           busy_run <= '0;
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R4
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && zdiv) |=> busy ##1 (done && div_err));

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_err) |-> ($stable(quot) && $stable(rem)));

  // R10
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= 8'(W + 1));
endmodule

bind seq_div_top seq_div_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .width_sel(width_sel),
  .divisor(divisor), .busy(busy), .done(done), .div_err(div_err),
  .quot(quot), .rem(rem)
);

// File: tb/tb_seq_div_top.sv
`timescale 1ns/1ps
module tb_seq_div_top;
  logic        clk, rst_n, start, op_signed;
  logic [1:0]  width_sel;
  logic [63:0] dvd_hi, dvd_lo, divisor;
  logic        busy, done, div_err;
  logic [63:0] quot, rem;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] exp_q = '0;
  logic [63:0] exp_r = '0;

  seq_div_top #(.W(64)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_signed(op_signed),
    .width_sel(width_sel), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
    .busy(busy), .done(done), .div_err(div_err), .quot(quot), .rem(rem)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic void ref_div(input bit sg, input logic [1:0] ws,
      input logic [63:0] hi, input logic [63:0] lo, input logic [63:0] dv,
      output bit err, output bit early, output logic [63:0] qo, output logic [63:0] ro);
    int n;
    logic [63:0] mk;
    logic [129:0] raw, dz;
    logic signed [129:0] nv, ds, qv, rv, mn, md, lim;
    n  = 8 << ws;
    mk = 64'hFFFF_FFFF_FFFF_FFFF >> (64 - n);
    if (ws == 2'd0) raw = 130'(lo[15:0]);
    else            raw = (130'(hi & mk) << n) | 130'(lo & mk);
    dz = 130'(dv & mk);
    if (sg && raw[2*n-1]) raw = raw | ~((130'd1 << (2*n)) - 130'd1);
    if (sg && dz[n-1])    dz  = dz  | ~((130'd1 << n) - 130'd1);
    nv = $signed(raw);
    ds = $signed(dz);
    mn = (nv < 0) ? -nv : nv;
    md = (ds < 0) ? -ds : ds;
    err = 1'b0;
    qo = '0;
    ro = '0;
    early = (ds == 0) || ((mn >>> n) >= md);
    if (ds == 0) begin
      err = 1'b1;
      return;
    end
    qv = nv / ds;
    rv = nv % ds;
    if (!sg) err = (qv >= (130'sd1 <<< n));
    else begin
      lim = 130'sd1 <<< (n - 1);
      err = (qv >= lim) || (qv < -lim);
    end
    qo = qv[63:0] & mk;
    ro = rv[63:0] & mk;
    if (ws == 2'd0) begin
      qo = {48'd0, ro[7:0], qo[7:0]};
      ro = '0;
    end
  endfunction

  // Drives one operation and compares busy/done on every clock until it ends.
  task automatic run_op(input bit sg, input logic [1:0] ws, input logic [63:0] hi,
                        input logic [63:0] lo, input logic [63:0] dv,
                        input bit poke, input string req);
    bit e_err, e_early;
    logic [63:0] eq, er;
    int lat;
    ref_div(sg, ws, hi, lo, dv, e_err, e_early, eq, er);
    lat = e_early ? 2 : (8 << ws) + 2;
    @(negedge clk);
    op_signed = sg; width_sel = ws; dvd_hi = hi; dvd_lo = lo; divisor = dv;
    start = 1'b1;
    @(negedge clk);
    for (int k = 1; k < lat; k++) begin
      chk(busy && !done, "R10", "busy/done while running", {62'd0, busy, done}, 64'd2);
      if (poke && k == 1) begin
        // R12: a start with a zero divisor during the run must be ignored
        start = 1'b1; divisor = '0; dvd_hi = '1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(!busy && done, "R10", "completion timing", {62'd0, busy, done}, 64'd1);
    chk(div_err == e_err, req, "div_err", 64'(div_err), 64'(e_err));
    if (!e_err) begin
      exp_q = eq;
      exp_r = er;
    end
    chk(quot == exp_q, req, "quot", quot, exp_q);
    chk(rem == exp_r, req, "rem", rem, exp_r);
    @(negedge clk);
    chk(!done, "R11", "done single cycle", 64'(done), 64'd0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op_signed = 1'b0; width_sel = 2'd0;
    dvd_hi = '0; dvd_lo = '0; divisor = '0;
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !div_err, "R1", "reset flags", {61'd0, busy, done, div_err}, 64'd0);
    chk(quot == '0 && rem == '0, "R1", "reset results", quot | rem, 64'd0);
    rst_n = 1'b1;

    // R3 R8: 0x0123 / 0x10 -> q 0x12 r 3; upper dvd_lo bits and dvd_hi ignored (R2)
    run_op(1'b0, 2'd0, 64'hDEAD, 64'hFFFF_0000_0000_0123, 64'hAB10, 1'b0, "R8");
    // R3 R9: 0x00010000 / 3
    run_op(1'b0, 2'd1, 64'hFFFF_0001, 64'hAAAA_0000, 64'h7777_0003, 1'b0, "R9");
    // R3: bit shifted out of the partial remainder must count
    run_op(1'b0, 2'd2, 64'h7FFF_FFFE, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 1'b0, "R3");
    run_op(1'b0, 2'd3, 64'h0123_4567_89AB_CDEF, 64'h0FED_CBA9_8765_4321,
           64'hFEDC_BA98_7654_3210, 1'b0, "R3");
    run_op(1'b0, 2'd3, 64'd0, 64'd1_000_000_007, 64'd97, 1'b0, "R2");
    // R4: zero divisor, results held
    run_op(1'b0, 2'd2, 64'd0, 64'd55, 64'hFFFF_FFFF_0000_0000, 1'b0, "R4");
    run_op(1'b1, 2'd0, 64'd0, 64'h0005, 64'h0000, 1'b0, "R4");
    // R5: upper half equals divisor
    run_op(1'b0, 2'd1, 64'h1234, 64'h0, 64'h1234, 1'b0, "R5");
    run_op(1'b1, 2'd3, 64'h8000_0000_0000_0000, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5");
    // R6: -7 / 2 -> -3 r -1 ; 100 / -7 -> -14 r 2
    run_op(1'b1, 2'd1, 64'hFFFF, 64'hFFF9, 64'h2, 1'b0, "R6");
    run_op(1'b1, 2'd2, 64'h0, 64'd100, 64'hFFFF_FFF9, 1'b0, "R6");
    run_op(1'b1, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FF9C,
           64'hFFFF_FFFF_FFFF_FFF9, 1'b0, "R6");
    // R7: -256/2 = -128 allowed, 256/2 = +128 rejected, -128/-1 rejected
    run_op(1'b1, 2'd0, 64'd0, 64'hFF00, 64'h02, 1'b0, "R7");
    run_op(1'b1, 2'd0, 64'd0, 64'h0100, 64'h02, 1'b0, "R7");
    run_op(1'b1, 2'd0, 64'd0, 64'hFF80, 64'hFF, 1'b0, "R7");
    run_op(1'b1, 2'd1, 64'hFFFF, 64'h8000, 64'h0001, 1'b0, "R7");
    // R12: start during a run is ignored
    run_op(1'b0, 2'd1, 64'h0002, 64'h3456, 64'h0100, 1'b1, "R12");
    run_op(1'b1, 2'd2, 64'hFFFF_FFFF, 64'h8765_4321, 64'h0000_1234, 1'b1, "R12");
    // mixed operations
    for (int i = 0; i < 80; i++) begin
      logic [63:0] rh, rl, rd;
      rh = {$urandom(), $urandom()} >> ($urandom() % 64);
      rl = {$urandom(), $urandom()};
      rd = {$urandom(), $urandom()};
      if (i % 9 == 0) rd = '0;
      run_op(1'($urandom() % 2), 2'($urandom() % 4), rh, rl, rd, 1'b0, "R6");
    end
    summary();
  end
endmodule